// File: doc/BRIEF.md
# SPI Diagnosis Slave with Chip Addressing

This block is the serial reporting side of a motor-bridge fault monitor. A host reads a one-byte fault register over 16-bit SPI frames. The first byte the host sends is an instruction: its top two bits carry a chip address, so up to four slaves can share one chip-select line. The second byte is ignored. While that instruction arrives, the slave returns a verification byte. It then returns a data byte that answers the instruction from the same frame. The SPI lines are asynchronous to the system clock. They are synchronised and their edges are detected on the system clock.

Fault sources arrive as level inputs and are latched into sticky flags. The register shows these flags through a priority encoding. A live under-voltage indication masks the per-output codes without destroying them. Every frame is checked for its length, its start condition and its instruction code. A bad frame raises a transfer-error flag in the next frame's verification byte. Only a fully valid read-diagnosis frame clears the latched faults. An edge on the bridge enable or disable input also clears them.

Top module: `spi_diag_slave`

## Requirements
- R1: After reset, `spi_miso_oe` is low, the transfer-error flag is 0 and the register reads 0xFF.
- R2: While `spi_cs_n` is low, MOSI is sampled on falling `spi_sclk` edges and MISO changes only after rising edges, MSB first. `spi_miso_oe` is low while `spi_cs_n` is high.
- R3: The first two instruction bits are a chip address that must equal 00. `spi_miso_oe` stays low for the first two bit times. On a mismatch it stays low for the whole frame, and the frame changes neither the flag nor the register.
- R4: The 16 output bits are a verification byte {0,1,0,1,0,1,0,flag} followed by the data byte. The top two verification bits fall in the address phase and are not driven.
- R5: Instruction byte 0x00 (address 00, opcode 0) returns the register content sampled at the eighth falling clock. Any other code returns 0xFF.
- R6: A matched frame is bad if its falling-clock count differs from 16, if `spi_sclk` is high when `spi_cs_n` falls, or if the instruction is not 0x00. A bad frame sets the flag, which appears in bit 0 of the next verification byte.
- R7: The flag clears at the end of a good frame that drove the flag bit (eighth output bit). Otherwise it holds.
- R8: Register layout: bit 7 is 0 on over-temperature, bit 6 is 0 on a short across the load, bit 5 is 0 during under-voltage, and bit 4 is 1. Bits [3:2] hold the output-2 code and bits [1:0] the output-1 code. The codes are 11 for no fault, 10 for a short to ground, 01 for a short to supply and 00 for an open load.
- R9: Priority: a latched short across the load forces both output codes to 11. Otherwise, per output, short to ground wins over short to supply, which wins over open load.
- R10: While under-voltage is present, bits [3:0] read 0000. The latched faults survive and reappear once it clears.
- R11: Faults are sticky. They clear only at the end of a valid 16-clock read-diagnosis frame, and a bad frame leaves them intact.
- R12: A rising edge on `drv_enable` or a falling edge on `drv_disable` clears the latched faults.
- R13: While `diag_mode_spi` is low, the frame logic is held idle, `spi_miso_oe` is low and the flag is reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| diag_mode_spi | input | 1 | High selects serial diagnosis; low holds the SPI logic idle |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | MISO drive enable (low = high impedance) |
| drv_enable | input | 1 | Bridge enable; rising edge clears faults |
| drv_disable | input | 1 | Bridge disable; falling edge clears faults |
| supply_uv | input | 1 | Live under-voltage indication |
| flt_otemp | input | 1 | Over-temperature event |
| flt_load_short | input | 1 | Short across the load event |
| flt_gnd_short | input | 2 | Short to ground, one bit per output |
| flt_sup_short | input | 2 | Short to supply, one bit per output |
| flt_open | input | 2 | Open load, one bit per output |

## Verification
The hardest state to reach is a register that stays masked by under-voltage while faults remain latched underneath. Any valid read taken during the masking would clear those faults. The bench therefore reads during under-voltage with a 17-clock frame. That frame still shows the masked byte but is invalid, so nothing is cleared. The following valid read then shows both the restored fault code and the transfer-error flag raised by the long frame. A frame that starts with the clock high, and a frame sent to another chip address, are also driven directly from the bench's frame task.

// File: rtl/spi_diag_pkg.sv
package spi_diag_pkg;
  localparam int ADDR_W = 2;
  localparam int INSTR_W = 8;
  localparam logic [ADDR_W-1:0] CHIP_ADDR = 2'b00;
  localparam logic [INSTR_W-ADDR_W-1:0] OP_RD_DIAG = '0;
  localparam logic [INSTR_W-1:0] RD_INSTR = {CHIP_ADDR, OP_RD_DIAG};
  localparam logic [6:0] VERIFY_PAT = 7'b0101010;

  typedef enum logic [1:0] {
    CODE_OPEN = 2'b00,
    CODE_SUP  = 2'b01,
    CODE_GND  = 2'b10,
    CODE_OK   = 2'b11
  } out_code_e;
endpackage

// File: rtl/spi_diag_sync.sv
module spi_diag_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_diag_store.sv
module spi_diag_store
  import spi_diag_pkg::*;
#(
  parameter int N_OUT = 2,
  localparam int VIEW_W = 4 + 2*N_OUT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              uv,
  input  logic              f_ot,
  input  logic              f_scol,
  input  logic [N_OUT-1:0]  f_gnd,
  input  logic [N_OUT-1:0]  f_sup,
  input  logic [N_OUT-1:0]  f_open,
  output logic [VIEW_W-1:0] view
);
  logic             ot_q, scol_q;
  logic [N_OUT-1:0] gnd_q, sup_q, open_q;
  logic [2*N_OUT-1:0] codes;

  always_ff @(posedge clk) begin
    if (rst) begin
      ot_q   <= 1'b0;
      scol_q <= 1'b0;
      gnd_q  <= '0;
      sup_q  <= '0;
      open_q <= '0;
    end else begin
      ot_q   <= (ot_q & ~clr) | f_ot;
      scol_q <= (scol_q & ~clr) | f_scol;
      gnd_q  <= (gnd_q & {N_OUT{~clr}}) | f_gnd;
      sup_q  <= (sup_q & {N_OUT{~clr}}) | f_sup;
      open_q <= (open_q & {N_OUT{~clr}}) | f_open;
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_code
    out_code_e c;
    always_comb begin
      if (scol_q)         c = CODE_OK;
      else if (gnd_q[g])  c = CODE_GND;
      else if (sup_q[g])  c = CODE_SUP;
      else if (open_q[g]) c = CODE_OPEN;
      else                c = CODE_OK;
    end
    assign codes[2*g +: 2] = c;
  end

  assign view = {~ot_q, ~scol_q, ~uv, 1'b1, (uv ? {2*N_OUT{1'b0}} : codes)};
endmodule

// File: rtl/spi_diag_frame.sv
module spi_diag_frame
  import spi_diag_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  localparam int BYTE_W = FRAME_BITS / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_en,
  input  logic              csn_q,
  input  logic              sck_q,
  input  logic              sdi_q,
  input  logic [BYTE_W-1:0] diag_view,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              rd_clear,
  output logic              frame_err,
  output logic              xfer_flag
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] CNT_ADDR  = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] CNT_INSTR = CNT_W'(BYTE_W - 1);

  logic csn_d, sck_d;
  logic csn_fall, csn_rise, sck_fall, sck_rise;
  logic active, addr_ok, addr_bad, bad_start, flag_sent;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_W-1:0] shin, instr, next_byte;
  logic [FRAME_BITS-1:0] out_word;
  logic err_c;

  assign csn_fall  = csn_d & ~csn_q;
  assign csn_rise  = ~csn_d & csn_q;
  assign sck_fall  = sck_d & ~sck_q;
  assign sck_rise  = ~sck_d & sck_q;
  assign next_byte = {shin[BYTE_W-2:0], sdi_q};
  assign err_c     = bad_start | (cnt != CNT_FULL) | (instr != RD_INSTR);

  always_ff @(posedge clk) begin
    if (rst) begin
      csn_d <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      csn_d <= csn_q;
      sck_d <= sck_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !mode_en) begin
      active    <= 1'b0;
      cnt       <= '0;
      shin      <= '0;
      instr     <= '1;
      addr_ok   <= 1'b0;
      addr_bad  <= 1'b0;
      bad_start <= 1'b0;
      flag_sent <= 1'b0;
      out_word  <= '1;
      sdo       <= 1'b1;
      sdo_oe    <= 1'b0;
      rd_clear  <= 1'b0;
      frame_err <= 1'b0;
      xfer_flag <= 1'b0;
    end else begin
      rd_clear  <= 1'b0;
      frame_err <= 1'b0;
      if (csn_fall) begin
        active    <= 1'b1;
        cnt       <= '0;
        bad_start <= sck_q;
        addr_ok   <= 1'b0;
        addr_bad  <= 1'b0;
        flag_sent <= 1'b0;
        instr     <= '1;
        out_word  <= {VERIFY_PAT, xfer_flag, {BYTE_W{1'b1}}};
        sdo_oe    <= 1'b0;
      end else if (active && csn_rise) begin
        active <= 1'b0;
        sdo_oe <= 1'b0;
        if (!addr_bad) begin
          if (err_c) begin
            xfer_flag <= 1'b1;
            frame_err <= 1'b1;
          end else begin
            rd_clear <= 1'b1;
            if (flag_sent) xfer_flag <= 1'b0;
          end
        end
      end else if (active) begin
        if (sck_rise) begin
          out_word <= {out_word[FRAME_BITS-2:0], 1'b1};
          if (addr_ok) begin
            sdo_oe <= 1'b1;
            sdo    <= out_word[FRAME_BITS-1];
            if (cnt == CNT_INSTR) flag_sent <= 1'b1;
          end
        end
        if (sck_fall) begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          shin <= next_byte;
          if (cnt == CNT_ADDR) begin
            addr_ok  <= (next_byte[ADDR_W-1:0] == CHIP_ADDR);
            addr_bad <= (next_byte[ADDR_W-1:0] != CHIP_ADDR);
          end
          if (cnt == CNT_INSTR && addr_ok) begin
            instr <= next_byte;
            out_word[FRAME_BITS-1 -: BYTE_W] <= (next_byte == RD_INSTR) ? diag_view : '1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_diag_slave.sv
module spi_diag_slave
  import spi_diag_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS = 16,
  parameter int N_OUT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             diag_mode_spi,
  input  logic             spi_cs_n,
  input  logic             spi_sclk,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic             spi_miso_oe,
  input  logic             drv_enable,
  input  logic             drv_disable,
  input  logic             supply_uv,
  input  logic             flt_otemp,
  input  logic             flt_load_short,
  input  logic [N_OUT-1:0] flt_gnd_short,
  input  logic [N_OUT-1:0] flt_sup_short,
  input  logic [N_OUT-1:0] flt_open
);
  localparam int BYTE_W = FRAME_BITS / 2;
  localparam int N_SYNC = 6;

  logic [N_SYNC-1:0] sync_q;
  logic csn_s, sck_s, sdi_s, en_s, dis_s, uv_s;
  logic en_d, dis_d;
  logic rd_clear, frame_err, xfer_flag, diag_clear;
  logic [BYTE_W-1:0] diag_view;

  spi_diag_sync #(
    .W(N_SYNC), .STAGES(SYNC_STAGES), .RST_VAL(6'b010001)
  ) u_sync (
    .clk(clk), .rst(rst),
    .d({supply_uv, drv_disable, drv_enable, spi_mosi, spi_sclk, spi_cs_n}),
    .q(sync_q)
  );

  assign {uv_s, dis_s, en_s, sdi_s, sck_s, csn_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d  <= 1'b0;
      dis_d <= 1'b1;
    end else begin
      en_d  <= en_s;
      dis_d <= dis_s;
    end
  end

  assign diag_clear = rd_clear | (en_s & ~en_d) | (~dis_s & dis_d);

  spi_diag_store #(.N_OUT(N_OUT)) u_store (
    .clk(clk), .rst(rst), .clr(diag_clear), .uv(uv_s),
    .f_ot(flt_otemp), .f_scol(flt_load_short),
    .f_gnd(flt_gnd_short), .f_sup(flt_sup_short), .f_open(flt_open),
    .view(diag_view)
  );

  spi_diag_frame #(.FRAME_BITS(FRAME_BITS)) u_frame (
    .clk(clk), .rst(rst), .mode_en(diag_mode_spi),
    .csn_q(csn_s), .sck_q(sck_s), .sdi_q(sdi_s),
    .diag_view(diag_view),
    .sdo(spi_miso), .sdo_oe(spi_miso_oe),
    .rd_clear(rd_clear), .frame_err(frame_err), .xfer_flag(xfer_flag)
  );
endmodule

// File: rtl/spi_diag_checker.sv
module spi_diag_checker #(
  parameter int N_OUT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_en,
  input logic             csn_s,
  input logic             sck_s,
  input logic             uv_s,
  input logic             miso,
  input logic             miso_oe,
  input logic             diag_clear,
  input logic [7:0]       diag_view,
  input logic             xfer_flag,
  input logic             frame_err,
  input logic             f_ot,
  input logic             f_scol,
  input logic [N_OUT-1:0] f_gnd,
  input logic [N_OUT-1:0] f_sup,
  input logic [N_OUT-1:0] f_open
);
  logic fault_any;
  assign fault_any = f_ot | f_scol | (|f_gnd) | (|f_sup) | (|f_open);

  // R2: no drive once chip select has been seen high twice
  assert_idle_hiz_R2: assert property (@(posedge clk) disable iff (rst)
    (csn_s && $past(csn_s)) |-> !miso_oe);

  // R2: MISO moves only right after a detected rising serial clock
  assert_shift_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (miso_oe && $past(miso_oe) && !$stable(miso)) |-> ($past(sck_s) && !$past(sck_s, 2)));

  // R13: mode low forces MISO off
  assert_mode_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !mode_en |=> !miso_oe);

  // R6: flag only rises with a detected bad frame
  assert_flag_from_err_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_flag) |-> frame_err);

  // R11: a clear with no new fault leaves the register empty
  assert_clear_empty_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(diag_clear) && !$past(fault_any) && !uv_s) |-> (diag_view == 8'hFF));
endmodule

bind spi_diag_slave spi_diag_checker #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst(rst), .mode_en(diag_mode_spi),
  .csn_s(csn_s), .sck_s(sck_s), .uv_s(uv_s),
  .miso(spi_miso), .miso_oe(spi_miso_oe),
  .diag_clear(diag_clear), .diag_view(diag_view),
  .xfer_flag(xfer_flag), .frame_err(frame_err),
  .f_ot(flt_otemp), .f_scol(flt_load_short),
  .f_gnd(flt_gnd_short), .f_sup(flt_sup_short), .f_open(flt_open)
);

// File: tb/tb_spi_diag_slave.sv
module tb_spi_diag_slave;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic diag_mode_spi = 1'b1;
  logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic drv_enable = 1'b0, drv_disable = 1'b1, supply_uv = 1'b0;
  logic flt_otemp = 1'b0, flt_load_short = 1'b0;
  logic [1:0] flt_gnd_short = '0, flt_sup_short = '0, flt_open = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_diag_slave dut (
    .clk(clk), .rst(rst), .diag_mode_spi(diag_mode_spi),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .drv_enable(drv_enable), .drv_disable(drv_disable), .supply_uv(supply_uv),
    .flt_otemp(flt_otemp), .flt_load_short(flt_load_short),
    .flt_gnd_short(flt_gnd_short), .flt_sup_short(flt_sup_short), .flt_open(flt_open)
  );

  // vector: [15] otemp, [14] load short, [13:12] gnd, [11:10] supply, [9:8] open, [7:0] expected byte
  localparam logic [15:0] VEC [10] = '{
    16'h00FF, 16'h807F, 16'h40BF, 16'h52BF, 16'h10FE,
    16'h08F7, 16'h03F0, 16'h29F8, 16'h05FD, 16'hA07B
  };

  logic [15:0] rx, oe;

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] tx, input int nclk, input bit start_hi);
    rx = '0;
    oe = '0;
    spi_sclk = start_hi;
    wclk(4);
    spi_cs_n = 1'b0;
    wclk(8);
    if (start_hi) begin
      spi_sclk = 1'b0;
      wclk(8);
    end
    for (int i = 0; i < nclk; i++) begin
      spi_mosi = (i < 16) ? tx[15-i] : 1'b0;
      wclk(8);
      spi_sclk = 1'b1;
      wclk(8);
      if (i < 16) begin
        rx[15-i] = spi_miso;
        oe[15-i] = spi_miso_oe;
      end
      spi_sclk = 1'b0;
      wclk(8);
    end
    spi_cs_n = 1'b1;
    wclk(12);
  endtask

  task automatic read_chk(input string req, input logic flag, input logic [7:0] data);
    frame(16'h0000, 16, 1'b0);
    chk({req, " oe"}, oe, 16'h3FFF);
    chk({req, " verify"}, {10'd0, rx[13:8]}, {10'd0, 5'b01010, flag});
    chk({req, " data"}, {8'd0, rx[7:0]}, {8'd0, data});
  endtask

  task automatic pulse_fault(input logic [15:0] v);
    {flt_otemp, flt_load_short, flt_gnd_short, flt_sup_short, flt_open} = v[15:8];
    wclk(3);
    {flt_otemp, flt_load_short, flt_gnd_short, flt_sup_short, flt_open} = '0;
    wclk(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wclk(5);
    rst = 1'b0;
    wclk(2);
    // R1: reset state
    chk("R1 oe", {15'd0, spi_miso_oe}, 16'h0);
    read_chk("R1", 1'b0, 8'hFF);

    // R8 R9 R11 R4 R5: vector table
    foreach (VEC[k]) begin
      pulse_fault(VEC[k]);
      read_chk("R8/R9 vec", 1'b0, VEC[k][7:0]);
      frame(16'h0000, 16, 1'b0);
      chk("R11 cleared", {8'd0, rx[7:0]}, 16'h00FF);
    end

    // R3: address mismatch ignored, no drive
    pulse_fault(16'h1000);
    frame(16'h4000, 16, 1'b0);
    chk("R3 mismatch oe", oe, 16'h0000);
    read_chk("R3 no clear, no flag", 1'b0, 8'hFE);

    // R5 R6 R7: unused opcode
    pulse_fault(16'h8000);
    frame(16'h0500, 16, 1'b0);
    chk("R5 unused data", {8'd0, rx[7:0]}, 16'h00FF);
    read_chk("R6 flag after unused, R11 kept", 1'b1, 8'h7F);
    read_chk("R7 flag cleared after sent", 1'b0, 8'hFF);

    // R6: short frame
    pulse_fault(16'h0800);
    frame(16'h0000, 15, 1'b0);
    read_chk("R6 short frame", 1'b1, 8'hF7);
    read_chk("R7 after short", 1'b0, 8'hFF);

    // R10 R6: long frame during under-voltage, then restore
    pulse_fault(16'h1000);
    supply_uv = 1'b1;
    wclk(6);
    frame(16'h0000, 17, 1'b0);
    chk("R10 masked data", {8'd0, rx[7:0]}, 16'h00D0);
    supply_uv = 1'b0;
    wclk(6);
    read_chk("R10 restored R6 long", 1'b1, 8'hFE);
    read_chk("R7 after long", 1'b0, 8'hFF);

    // R6: clock high at chip-select fall
    pulse_fault(16'h0100);
    frame(16'h0000, 16, 1'b1);
    read_chk("R6 start high", 1'b1, 8'hFC);
    read_chk("R7 after start high", 1'b0, 8'hFF);

    // R12: enable rise and disable fall
    pulse_fault(16'h8000);
    drv_enable = 1'b1;
    wclk(8);
    drv_enable = 1'b0;
    wclk(4);
    read_chk("R12 enable rise", 1'b0, 8'hFF);
    pulse_fault(16'h4000);
    drv_disable = 1'b0;
    wclk(8);
    drv_disable = 1'b1;
    wclk(4);
    read_chk("R12 disable fall", 1'b0, 8'hFF);

    // R13: mode low holds idle and resets flag
    frame(16'h0000, 15, 1'b0);
    diag_mode_spi = 1'b0;
    wclk(4);
    frame(16'h0000, 16, 1'b0);
    chk("R13 no drive", oe, 16'h0000);
    diag_mode_spi = 1'b1;
    wclk(4);
    read_chk("R13 flag reset", 1'b0, 8'hFF);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule